// File: doc/BRIEF.md
# Two-Phase Password Verification Controller

This block guards a small bank of 24-bit passwords. There are two password kinds, write and read, and each has a number of sets. Every password has an 8-bit attempts counter of its own. A check takes two verify commands in a row that name the same password.

The first command only arms the check. It charges one attempt by turning the lowest remaining 1 bit of the counter into 0, and its password bytes are ignored. The second command compares the presented bytes with the stored password. On a match it restores the counter to all ones and grants access for that password.

No counter changes while a command is issued. Each command only stages its result. A stop strobe then launches a timed write cycle, and the staged value is committed when that cycle ends. During the cycle a busy flag is raised and poll requests are refused. Once the cycle has finished, a poll with the proper code is acknowledged and returns the counter of the password addressed last. The stored passwords are fixed by a parameter, and the counters are held in registers.

Top module: `pwd_verify`

## Requirements
- R1: After reset every attempts counter reads 0xFF, every grant flag is 0 and busy is 0.
- R2: A verify command arms a check when no check is pending or when a check is pending for a different selector. Its password bytes are ignored, and after the write cycle the selected counter has its lowest 1 bit cleared.
- R3: A verify command with the same selector as the pending armed check compares its 24-bit password with the stored one. On a match the counter reads 0xFF after the write cycle.
- R4: A comparison that fails leaves the counter at its armed value and sets no grant. The pending check is consumed, so the next command arms again.
- R5: The selector is {r, p}: r=0 picks a write password, r=1 a read password, and p picks the set. Selector value 1 (r=0, p=1) is the secure code. Each selector has its own counter, password and grant, and its commands never touch the others.
- R6: A write cycle starts only on a stop strobe after at least one accepted command. Busy rises in the cycle after the stop and stays high for exactly WRITE_CYCLES cycles. A stop with nothing staged has no effect.
- R7: Verify commands and stop strobes that arrive while busy is high are ignored.
- R8: pollAck is 1 only when pollValid is high, pollCode is 0xBD and busy is low. When acknowledged, pollData is the counter of the last accepted selector (selector 0 after reset). Otherwise pollData is 0.
- R9: When a check is armed for one selector, a command for another selector is treated as a fresh arming and never as a comparison.
- R10: A counter at 0x00 is locked. Commands on it never compare and never grant, and the counter stays at 0x00.
- R11: A grant flag rises only when a write cycle for a matching comparison ends, and it stays high until reset.
- R12: A counter changes only in the cycle in which a write cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle verify command strobe |
| cmdSel | input | SET_BITS+1 | Selector {r, p} |
| cmdPw | input | 24 | Presented password, three bytes |
| stopValid | input | 1 | Stop strobe that launches the write cycle |
| pollValid | input | 1 | Poll request |
| pollCode | input | 8 | Poll command code, 0xBD is accepted |
| busy | output | 1 | Write cycle in progress |
| pollAck | output | 1 | Poll acknowledged |
| pollData | output | 8 | Attempts counter of the last selector when acknowledged |
| grant | output | 2**(SET_BITS+1) | Access granted, one bit per selector |

## Verification
The bench goes after the ordering corner cases:
- A design that compares on the first command would grant access without charging an attempt.
- A design that treats a command with a new selector as the second half of a check would let the arming of one password unlock another.
- A design that commits at command time would show a new counter before the stop strobe, or would let a command issued during busy change a counter.
- A design that does not lock at 0x00 would restore a drained counter to 0xFF on a correct password.
- A design that acknowledges polls during the write cycle, or for a wrong code, would return data too early.

// File: rtl/pwv_pkg.sv
package pwv_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic stageInit;   // stage an arming result for cmdSel
    logic stageCheck;  // stage a comparison result for cmdSel
    logic commit;      // write cycle finished: apply the staged value
  } pwvStrobe_t;

  localparam logic [7:0] POLL_CODE = 8'hBD;
  localparam int         CNT_W     = 8;
  localparam int         PW_W      = 24;

endpackage

// File: rtl/pwv_control.sv
module pwv_control
  import pwv_pkg::*;
#(
  parameter int SEL_W        = 2,
  parameter int WRITE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [SEL_W-1:0] cmdSel,
  input  logic             stopValid,
  input  logic             lockedSel,
  output pwvStrobe_t       strobe,
  output logic             busy
);

  localparam int CYC_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WRITING
  } ctrlState_t;

  ctrlState_t       state;
  ctrlState_t       stateNext;
  logic [CYC_W-1:0] cycCnt;
  logic             pending;
  logic [SEL_W-1:0] pendSel;
  logic             accept;
  logic             isCheck;
  logic             cycDone;

  // Commands are only taken outside the write cycle.
  assign accept  = cmdValid && (state != ST_WRITING);
  // A comparison needs a pending arming for the same selector and an unlocked counter.
  assign isCheck = pending && (pendSel == cmdSel) && !lockedSel;
  assign cycDone = (state == ST_WRITING) && (cycCnt == LAST_CYC);

  always_comb begin
    strobe            = '0;
    strobe.stageInit  = accept && !isCheck;
    strobe.stageCheck = accept && isCheck;
    strobe.commit     = cycDone;
  end

  assign busy = (state == ST_WRITING);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNext = ST_ARMED;
      ST_ARMED:   if (stopValid) stateNext = ST_WRITING;
      ST_WRITING: if (cycDone) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WRITING) cycCnt <= cycDone ? '0 : cycCnt + 1'b1;
      else                     cycCnt <= '0;
    end
  end

  // Tracks which selector holds an armed check.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendSel <= '0;
    end else if (accept) begin
      if (isCheck) begin
        pending <= 1'b0;
      end else begin
        pending <= !lockedSel;
        pendSel <= cmdSel;
      end
    end
  end

endmodule

// File: rtl/pwv_datapath.sv
module pwv_datapath
  import pwv_pkg::*;
#(
  parameter int                    SEL_W   = 2,
  parameter int                    NUM_PW  = 4,
  parameter logic [NUM_PW*PW_W-1:0] PW_INIT = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pwvStrobe_t               strobe,
  input  logic [SEL_W-1:0]         cmdSel,
  input  logic [PW_W-1:0]          cmdPw,
  input  logic                     pollEn,
  output logic                     lockedSel,
  output logic [NUM_PW*CNT_W-1:0]  cntAll,
  output logic [NUM_PW-1:0]        grant,
  output logic [CNT_W-1:0]         pollData
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  logic [CNT_W-1:0] cntArr [NUM_PW];
  logic [PW_W-1:0]  pwArr  [NUM_PW];

  logic [SEL_W-1:0] stIdx;
  logic [CNT_W-1:0] stVal;
  logic             stGrant;

  logic [CNT_W-1:0] selCnt;
  logic [CNT_W-1:0] armedVal;
  logic             pwMatch;

  assign selCnt    = cntArr[cmdSel];
  assign lockedSel = (selCnt == '0);
  // Lowest remaining 1 bit becomes 0.
  assign armedVal  = selCnt & (selCnt - 1'b1);
  assign pwMatch   = (pwArr[cmdSel] == cmdPw) && !lockedSel;

  // Staging register: holds the value to commit at the end of the write cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stIdx   <= '0;
      stVal   <= CNT_FULL;
      stGrant <= 1'b0;
    end else if (strobe.stageInit) begin
      stIdx   <= cmdSel;
      stVal   <= lockedSel ? '0 : armedVal;
      stGrant <= 1'b0;
    end else if (strobe.stageCheck) begin
      stIdx   <= cmdSel;
      stVal   <= pwMatch ? CNT_FULL : selCnt;
      stGrant <= pwMatch;
    end
  end

  for (genvar i = 0; i < NUM_PW; i++) begin : gEntry
    logic hit;
    assign hit      = strobe.commit && (stIdx == SEL_W'(i));
    assign pwArr[i] = PW_INIT[i*PW_W +: PW_W];
    assign cntAll[i*CNT_W +: CNT_W] = cntArr[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntArr[i] <= CNT_FULL;
        grant[i]  <= 1'b0;
      end else if (hit) begin
        cntArr[i] <= stVal;
        if (stGrant) grant[i] <= 1'b1;
      end
    end
  end

  assign pollData = pollEn ? cntArr[stIdx] : '0;

endmodule

// File: rtl/pwd_verify.sv
module pwd_verify
  import pwv_pkg::*;
#(
  parameter int SET_BITS     = 1,
  parameter int WRITE_CYCLES = 16,
  parameter logic [(2**(SET_BITS+1))*24-1:0] PW_INIT =
    {24'hA15_5AA, 24'h2C_AA55, 24'h55A1_2C, 24'hAA2C_A1}
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic [SET_BITS:0]            cmdSel,
  input  logic [23:0]                  cmdPw,
  input  logic                         stopValid,
  input  logic                         pollValid,
  input  logic [7:0]                   pollCode,
  output logic                         busy,
  output logic                         pollAck,
  output logic [7:0]                   pollData,
  output logic [(2**(SET_BITS+1))-1:0] grant
);

  localparam int SEL_W  = SET_BITS + 1;
  localparam int NUM_PW = 2 ** SEL_W;

  pwvStrobe_t               strobe;
  logic                     lockedSel;
  logic [NUM_PW*CNT_W-1:0]  cntAll;

  assign pollAck = pollValid && (pollCode == POLL_CODE) && !busy;

  pwv_control #(
    .SEL_W        (SEL_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdSel    (cmdSel),
    .stopValid (stopValid),
    .lockedSel (lockedSel),
    .strobe    (strobe),
    .busy      (busy)
  );

  pwv_datapath #(
    .SEL_W   (SEL_W),
    .NUM_PW  (NUM_PW),
    .PW_INIT (PW_INIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdSel    (cmdSel),
    .cmdPw     (cmdPw),
    .pollEn    (pollAck),
    .lockedSel (lockedSel),
    .cntAll    (cntAll),
    .grant     (grant),
    .pollData  (pollData)
  );

endmodule

// File: rtl/pwv_checker.sv
module pwv_checker #(
  parameter int NUM_PW       = 4,
  parameter int CNT_W        = 8,
  parameter int WRITE_CYCLES = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busy,
  input logic [NUM_PW-1:0]       grant,
  input logic [NUM_PW*CNT_W-1:0] cntAll
);

  localparam int LEN_W = $clog2(WRITE_CYCLES + 2);

  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R6: every write cycle lasts exactly WRITE_CYCLES cycles
  assert_busy_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == LEN_W'(WRITE_CYCLES)));

  // R11: grants never drop outside reset
  assert_grant_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (($past(grant) & ~grant) == '0));

  // R11: grants only rise as a write cycle ends
  assert_grant_at_commit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (grant != $past(grant)) |-> $fell(busy));

  // R12: counters only move as a write cycle ends
  assert_cnt_at_commit_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cntAll != $past(cntAll)) |-> $fell(busy));

  for (genvar i = 0; i < NUM_PW; i++) begin : gStep
    // R2: a counter either restores to all ones or loses exactly one 1 bit
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rstN)
      (cntAll[i*CNT_W +: CNT_W] != $past(cntAll[i*CNT_W +: CNT_W])) |->
        ((cntAll[i*CNT_W +: CNT_W] == '1) ||
         ($countones(cntAll[i*CNT_W +: CNT_W]) + 1 ==
          $countones($past(cntAll[i*CNT_W +: CNT_W])))));
  end

endmodule

bind pwd_verify pwv_checker #(
  .NUM_PW       (NUM_PW),
  .CNT_W        (pwv_pkg::CNT_W),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .grant  (grant),
  .cntAll (cntAll)
);

// File: tb/pwd_verify_tb.sv
module pwd_verify_tb;

  localparam int W = 12;
  localparam logic [95:0] TB_PW = {24'h3C5A0F, 24'h112233, 24'hC0FFEE, 24'h0A0B0C};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdSel = '0;
  logic [23:0] cmdPw = '0;
  logic        stopValid = 1'b0;
  logic        pollValid = 1'b0;
  logic [7:0]  pollCode = '0;
  logic        busy;
  logic        pollAck;
  logic [7:0]  pollData;
  logic [3:0]  grant;

  int errors = 0;
  int checks = 0;

  // reference model state
  int          mcnt [4];
  bit          mgrant [4];
  logic [23:0] mpw [4];
  bit          mpend;
  int          mprp;
  bit          mstaged;
  int          msidx;
  int          msval;
  bit          msgrant;

  always #5 clk = ~clk;

  pwd_verify #(.SET_BITS(1), .WRITE_CYCLES(W), .PW_INIT(TB_PW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSel(cmdSel), .cmdPw(cmdPw),
    .stopValid(stopValid), .pollValid(pollValid), .pollCode(pollCode),
    .busy(busy), .pollAck(pollAck), .pollData(pollData), .grant(grant));

  function automatic int clearLow(int v);
    return v & (v - 1);
  endfunction

  function automatic logic [3:0] expGrant();
    logic [3:0] g;
    for (int i = 0; i < 4; i++) g[i] = mgrant[i];
    return g;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mcnt[i] = 255; mgrant[i] = 0; mpw[i] = TB_PW[i*24 +: 24];
    end
    mpend = 0; mprp = 0; mstaged = 0; msidx = 0; msval = 255; msgrant = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic doCmd(int rp, logic [23:0] pw, bit whileBusy);
    bit locked;
    bit m;
    @(negedge clk);
    cmdValid = 1'b1; cmdSel = 2'(rp); cmdPw = pw;
    @(negedge clk);
    cmdValid = 1'b0;
    if (!whileBusy) begin
      locked = (mcnt[rp] == 0);
      if (mpend && mprp == rp && !locked) begin
        m = (pw == mpw[rp]);
        msval = m ? 255 : mcnt[rp]; msgrant = m; mpend = 0;
      end else begin
        msval = locked ? 0 : clearLow(mcnt[rp]); msgrant = 0;
        mpend = !locked; mprp = rp;
      end
      mstaged = 1; msidx = rp;
    end
  endtask

  task automatic doPoll(logic [7:0] code, bit expAck, string req);
    @(negedge clk);
    pollValid = 1'b1; pollCode = code;
    #1;
    chk(pollAck == expAck, req, pollAck, expAck);
    chk(pollData == (expAck ? 8'(mcnt[msidx]) : 8'h00), req, pollData,
        expAck ? mcnt[msidx] : 0);
    pollValid = 1'b0;
  endtask

  // Stop, then follow the write cycle to its end.
  task automatic doStop(bit busyPoll);
    int n;
    @(negedge clk);
    stopValid = 1'b1;
    @(negedge clk);
    stopValid = 1'b0;
    chk(busy == mstaged, "R6 busy after stop", busy, mstaged);
    chk(grant == expGrant(), "R12 no update before write end", grant, expGrant());
    if (mstaged) begin
      n = 0;
      if (busyPoll) begin
        pollValid = 1'b1; pollCode = 8'hBD; #1;
        chk(pollAck == 1'b0, "R8 no ack while busy", pollAck, 0);
        pollValid = 1'b0;
      end
      while (busy && n < 4 * W) begin
        n++;
        @(negedge clk);
      end
      chk(n == W, "R6 busy length", n, W);
      mcnt[msidx] = msval;
      if (msgrant) mgrant[msidx] = 1;
      mstaged = 0;
    end
  endtask

  task automatic checkState(string req);
    doPoll(8'hBD, 1'b1, req);
    chk(grant == expGrant(), req, grant, expGrant());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    int rp;
    seed = 32'h5EED_0153;
    void'($urandom(seed));
    modelReset();
    doReset();

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(grant == 4'h0, "R1 grant", grant, 0);
    doPoll(8'hBD, 1'b1, "R1 counter FF");

    // R6 stop with nothing staged
    doStop(1'b0);
    doPoll(8'h3C, 1'b0, "R8 wrong code refused");

    // R2 arming on the secure code (R5 selector 1) with garbage data
    doCmd(1, mpw[1] ^ 24'hFFFFFF, 1'b0);
    doStop(1'b1);
    checkState("R2 arming clears lowest bit");
    // R3 correct comparison restores and grants
    doCmd(1, mpw[1], 1'b0);
    doStop(1'b0);
    checkState("R3 match restores FF");
    checkState("R11 grant for selector 1");

    // R4 mismatch
    doCmd(2, 24'h0, 1'b0); doStop(1'b0);
    doCmd(2, mpw[2] ^ 24'h1, 1'b0); doStop(1'b0);
    checkState("R4 mismatch keeps armed value");
    doCmd(2, mpw[2], 1'b0); doStop(1'b0);
    checkState("R4 pending consumed, re-arm");

    // R9 different selector re-arms
    doCmd(3, 24'h0, 1'b0); doStop(1'b0);
    doCmd(0, mpw[0], 1'b0); doStop(1'b0);
    checkState("R9 new selector arms");

    // R7 command and stop while busy are ignored
    doCmd(3, 24'h0, 1'b0);
    @(negedge clk); stopValid = 1'b1; @(negedge clk); stopValid = 1'b0;
    cmdValid = 1'b1; cmdSel = 2'd3; cmdPw = mpw[3];
    @(negedge clk); cmdValid = 1'b0; stopValid = 1'b1;
    @(negedge clk); stopValid = 1'b0;
    while (busy) @(negedge clk);
    mcnt[msidx] = msval; mstaged = 0;
    checkState("R7 busy command ignored");
    doStop(1'b0);
    checkState("R7 busy stop ignored");
    doCmd(3, mpw[3], 1'b0); doStop(1'b0);
    checkState("R5 selector 3 grant");

    // R10 drain selector 0 to lock
    for (int k = 0; k < 10; k++) begin
      doCmd(0, 24'h0, 1'b0); doStop(1'b0);
      doCmd(0, 24'h777777, 1'b0); doStop(1'b0);
    end
    checkState("R10 drained");
    doCmd(0, mpw[0], 1'b0); doStop(1'b0);
    doCmd(0, mpw[0], 1'b0); doStop(1'b0);
    checkState("R10 locked stays zero");
    chk(grant[0] == 1'b0, "R10 no grant when locked", grant[0], 0);

    // random phase
    doReset();
    checkState("R1 after second reset");
    for (int it = 0; it < 250; it++) begin
      rp = int'($urandom_range(3, 0));
      if ($urandom_range(1, 0) == 1) doCmd(rp, mpw[rp], 1'b0);
      else doCmd(rp, 24'($urandom()), 1'b0);
      if ($urandom_range(3, 0) != 0) begin
        doStop($urandom_range(1, 0) == 1);
        checkState("R5 random sequence");
      end
    end
    doStop(1'b0);
    checkState("R3 random final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule